// File: doc/BRIEF.md
# Power Mode and Clock Gating Controller

This block manages the power-saving states of a small 8-bit microcontroller. It holds an 8-bit power-control register that the CPU writes over a simple one-cycle write strobe. From that register and from its wake inputs it drives three enables: a CPU clock enable, a peripheral clock enable and an oscillator-run signal. It also produces a clock-enable strobe that slows the whole device to one thirty-second of its normal rate.

Three modes are provided. Idle stops only the CPU clock. Power-down stops the oscillator and with it every clock. Slow-down thins the common clock enable to one cycle in 32, and it can run together with idle. Idle and power-down are each entered through a guarded pair of consecutive writes, so that a single stray write cannot stop the CPU. Idle ends on an enabled peripheral interrupt. Power-down ends on a low level sampled on either of two wake pins, followed by a warm-up interval in which the oscillator runs but all clocks stay gated.

Top module: `pmc_power_ctrl`

## Requirements
- R1: After reset the register reads 0x00, and cpu_clk_en, periph_clk_en, osc_run and slow_tick are all 1.
- R2: A write with bit 0 set, followed directly by a write with bit 5 set, enters idle after the second write: cpu_clk_en goes to 0, periph_clk_en and osc_run stay 1, and register bit 5 reads 1.
- R3: A write with bit 1 set, followed directly by a write with bit 6 set, enters power-down: cpu_clk_en, periph_clk_en and osc_run all go to 0, and register bit 6 reads 1.
- R4: Register bits 0 and 1 read back the arm flags. A write that follows an arming write but lacks the partner bit (bit 5 for bit 0, bit 6 for bit 1) clears that arm flag and enters no mode; the partner bit is then ignored even if set on this write. Bits 5 and 6 written without a prior arm enter no mode.
- R5: In idle, wake_irq sampled high on a clock edge returns the block to running on that edge: cpu_clk_en is 1 and bits 5, 0 and 1 read 0.
- R6: In power-down, wake_irq has no effect. A 0 sampled on wake_a_n or wake_b_n starts a warm-up of WARM_CYCLES cycles with osc_run 1 and both clock enables 0 and bit 6 still 1; after it the block runs at full enable with bit 6 cleared.
- R7: Bit 4 enables slow-down. With it set, slow_tick is 1 in exactly one cycle out of 32, first in the 32nd cycle after the enabling write; with it clear, slow_tick is 1 every cycle while the oscillator runs.
- R8: Register writes presented while the CPU clock is gated (idle, power-down or warm-up) are ignored.
- R9: Slow-down continues during idle; during power-down slow_tick is 0 and the divider count is held, resuming where it stopped.
- R10: When both arm flags are set and the next write carries bits 5 and 6, power-down is entered.
- R11: Bits 2, 3 and 7 are plain storage, reading back the value last written while running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_data | input | 8 | Register write data |
| wake_irq | input | 1 | Any enabled peripheral interrupt, active high |
| wake_a_n | input | 1 | External interrupt wake pin, active low |
| wake_b_n | input | 1 | Serial receive wake pin, active low |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run request |
| slow_tick | output | 1 | Common rate strobe, divided by 32 in slow-down |
| pwr_reg | output | 8 | Power-control register readback |

## Verification
A wrong arm flag shows on pwr_reg bit 0 or 1 one cycle after the offending write, and a wrongly taken mode shows on the clock enables in that same cycle, since all outputs come straight from registered state. A miscounted warm-up or divider shows as an enable or strobe edge one or more cycles early or late, which the per-cycle comparison against the bench model catches at the first differing cycle. A lost wake shows as a clock enable stuck at 0 from the cycle after the wake level was presented.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_PDOWN = 2'd2,
        MODE_WARM  = 2'd3
    } pmc_mode_t;

    localparam int BIT_IDLE_ARM = 0;
    localparam int BIT_PD_ARM   = 1;
    localparam int BIT_GP_LO    = 2;
    localparam int BIT_GP_MID   = 3;
    localparam int BIT_SLOW     = 4;
    localparam int BIT_IDLE_GO  = 5;
    localparam int BIT_PD_GO    = 6;
    localparam int BIT_GP_HI    = 7;

endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       cpu_run,
    output logic       idle_arm,
    output logic       pd_arm,
    output logic       slow_en,
    output logic [2:0] gp_bits,
    output logic       enter_idle,
    output logic       enter_pd
);
    import pmc_pkg::*;

    typedef struct packed {
        logic       idle_arm;
        logic       pd_arm;
        logic       slow;
        logic [2:0] gp;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       accept;

    always_comb begin
        st_d       = st_q;
        accept     = wr_en & cpu_run;
        enter_idle = accept & st_q.idle_arm & wr_data[BIT_IDLE_GO];
        enter_pd   = accept & st_q.pd_arm & wr_data[BIT_PD_GO];
        if (accept) begin
            // an armed flag is consumed by the very next write, whatever it carries
            st_d.idle_arm = st_q.idle_arm ? 1'b0 : wr_data[BIT_IDLE_ARM];
            st_d.pd_arm   = st_q.pd_arm   ? 1'b0 : wr_data[BIT_PD_ARM];
            st_d.slow     = wr_data[BIT_SLOW];
            st_d.gp       = {wr_data[BIT_GP_HI], wr_data[BIT_GP_MID], wr_data[BIT_GP_LO]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle_arm = st_q.idle_arm;
    assign pd_arm   = st_q.pd_arm;
    assign slow_en  = st_q.slow;
    assign gp_bits  = st_q.gp;

    assert_arm_broken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.idle_arm && wr_en && cpu_run && !wr_data[BIT_IDLE_GO]) |=> !st_q.idle_arm);

    assert_pd_arm_broken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pd_arm && wr_en && cpu_run && !wr_data[BIT_PD_GO]) |=> !st_q.pd_arm);

    assert_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_run) |=> ($stable(st_q.slow) && $stable(st_q.gp)));

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm #(
    parameter int WARM_CYCLES = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enter_idle,
    input  logic                enter_pd,
    input  logic                wake_irq,
    input  logic                wake_a_n,
    input  logic                wake_b_n,
    output pmc_pkg::pmc_mode_t  mode
);
    import pmc_pkg::*;

    localparam int WARM_LIM = (WARM_CYCLES < 1) ? 1 : WARM_CYCLES;
    localparam int CW       = $clog2(WARM_LIM + 1);
    localparam logic [CW-1:0] WARM_LAST = CW'(WARM_LIM - 1);

    typedef struct packed {
        pmc_mode_t  mode;
        logic [CW-1:0] warm_cnt;
    } fsm_state_t;

    fsm_state_t st_d, st_q;
    logic       pin_wake;

    always_comb begin
        st_d     = st_q;
        pin_wake = !wake_a_n || !wake_b_n;
        unique case (st_q.mode)
            MODE_RUN: begin
                if (enter_pd)        st_d.mode = MODE_PDOWN;
                else if (enter_idle) st_d.mode = MODE_IDLE;
            end
            MODE_IDLE: begin
                if (wake_irq) st_d.mode = MODE_RUN;
            end
            MODE_PDOWN: begin
                if (pin_wake) begin
                    st_d.mode     = MODE_WARM;
                    st_d.warm_cnt = '0;
                end
            end
            MODE_WARM: begin
                if (st_q.warm_cnt == WARM_LAST) st_d.mode = MODE_RUN;
                else                            st_d.warm_cnt = st_q.warm_cnt + 1'b1;
            end
            default: st_d.mode = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_RUN, warm_cnt: '0};
        else        st_q <= st_d;
    end

    assign mode = st_q.mode;

    assert_idle_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_IDLE && wake_irq) |=> (st_q.mode == MODE_RUN));

    assert_pd_holds_on_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_PDOWN && wake_a_n && wake_b_n) |=> (st_q.mode == MODE_PDOWN));

    assert_pin_starts_warm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_PDOWN && (!wake_a_n || !wake_b_n)) |=> (st_q.mode == MODE_WARM));

    assert_warm_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_WARM && st_q.warm_cnt == WARM_LAST) |=> (st_q.mode == MODE_RUN));

    assert_pd_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_RUN && enter_pd) |=> (st_q.mode == MODE_PDOWN));

endmodule

// File: rtl/pmc_slow_div.sv
module pmc_slow_div #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_en,
    input  logic osc_on,
    output logic tick
);
    localparam int DW = (DIV < 2) ? 1 : $clog2(DIV);
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);
    localparam bit POW2 = (DIV >= 2) && ((DIV & (DIV - 1)) == 0);

    logic [DW-1:0] cnt_d, cnt_q;
    logic [DW-1:0] cnt_inc;

    generate
        if (POW2) begin : g_wrap_free
            assign cnt_inc = cnt_q + 1'b1;
        end else begin : g_wrap_cmp
            assign cnt_inc = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    endgenerate

    always_comb begin
        cnt_d = cnt_q;
        if (!slow_en)    cnt_d = '0;
        else if (osc_on) cnt_d = cnt_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = osc_on && (!slow_en || cnt_q == LAST);

    assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_en && tick && DIV > 1) |=> (!tick || !slow_en));

    assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_en && !osc_on) |=> ($stable(cnt_q) || !slow_en));

endmodule

// File: rtl/pmc_power_ctrl.sv
module pmc_power_ctrl #(
    parameter int WARM_CYCLES = 1024,
    parameter int SLOW_DIV    = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wake_irq,
    input  logic       wake_a_n,
    input  logic       wake_b_n,
    output logic       cpu_clk_en,
    output logic       periph_clk_en,
    output logic       osc_run,
    output logic       slow_tick,
    output logic [7:0] pwr_reg
);
    import pmc_pkg::*;

    pmc_mode_t  mode;
    logic       cpu_run;
    logic       idle_arm, pd_arm, slow_en;
    logic [2:0] gp_bits;
    logic       enter_idle, enter_pd;

    assign cpu_run       = (mode == MODE_RUN);
    assign cpu_clk_en    = cpu_run;
    assign periph_clk_en = (mode == MODE_RUN) || (mode == MODE_IDLE);
    assign osc_run       = (mode != MODE_PDOWN);

    pmc_ctrl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cpu_run    (cpu_run),
        .idle_arm   (idle_arm),
        .pd_arm     (pd_arm),
        .slow_en    (slow_en),
        .gp_bits    (gp_bits),
        .enter_idle (enter_idle),
        .enter_pd   (enter_pd)
    );

    pmc_mode_fsm #(.WARM_CYCLES(WARM_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_idle (enter_idle),
        .enter_pd   (enter_pd),
        .wake_irq   (wake_irq),
        .wake_a_n   (wake_a_n),
        .wake_b_n   (wake_b_n),
        .mode       (mode)
    );

    pmc_slow_div #(.DIV(SLOW_DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .slow_en (slow_en),
        .osc_on  (osc_run),
        .tick    (slow_tick)
    );

    always_comb begin
        pwr_reg               = '0;
        pwr_reg[BIT_IDLE_ARM] = idle_arm;
        pwr_reg[BIT_PD_ARM]   = pd_arm;
        pwr_reg[BIT_GP_LO]    = gp_bits[0];
        pwr_reg[BIT_GP_MID]   = gp_bits[1];
        pwr_reg[BIT_SLOW]     = slow_en;
        pwr_reg[BIT_IDLE_GO]  = (mode == MODE_IDLE);
        pwr_reg[BIT_PD_GO]    = (mode == MODE_PDOWN) || (mode == MODE_WARM);
        pwr_reg[BIT_GP_HI]    = gp_bits[2];
    end

    assert_idle_keeps_periph_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && enter_idle && !enter_pd) |=> (!cpu_clk_en && periph_clk_en && osc_run));

    assert_pd_stops_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && enter_pd) |=> (!cpu_clk_en && !periph_clk_en && !osc_run));

endmodule

// File: tb/pmc_power_ctrl_tb.sv
module pmc_power_ctrl_tb_top;

    localparam int WARM = 16;
    localparam int DIVN = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wake_irq = 1'b0;
    logic       wake_a_n = 1'b1;
    logic       wake_b_n = 1'b1;
    logic       cpu_clk_en, periph_clk_en, osc_run, slow_tick;
    logic [7:0] pwr_reg;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    pmc_power_ctrl #(.WARM_CYCLES(WARM), .SLOW_DIV(DIVN)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wake_irq(wake_irq), .wake_a_n(wake_a_n), .wake_b_n(wake_b_n),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .osc_run(osc_run), .slow_tick(slow_tick), .pwr_reg(pwr_reg)
    );

    // behavioural model: 0 running, 1 idle, 2 power-down, 3 warm-up
    int m_mode = 0, m_wc = 0, m_ia = 0, m_pa = 0, m_slow = 0, m_dc = 0;
    int m_gp2 = 0, m_gp3 = 0, m_gp7 = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            int om, os;
            om = m_mode;
            os = m_slow;
            if (om == 0 && wr_en) begin
                int gi, gp;
                gi = m_ia & wr_data[5];
                gp = m_pa & wr_data[6];
                m_ia   = (m_ia != 0) ? 0 : int'(wr_data[0]);
                m_pa   = (m_pa != 0) ? 0 : int'(wr_data[1]);
                m_slow = wr_data[4];
                m_gp2  = wr_data[2];
                m_gp3  = wr_data[3];
                m_gp7  = wr_data[7];
                if (gp != 0)      m_mode = 2;
                else if (gi != 0) m_mode = 1;
            end else if (om == 1) begin
                if (wake_irq) m_mode = 0;
            end else if (om == 2) begin
                if (!wake_a_n || !wake_b_n) begin
                    m_mode = 3;
                    m_wc = 0;
                end
            end else if (om == 3) begin
                if (m_wc == WARM - 1) m_mode = 0;
                else m_wc++;
            end
            if (os == 0)      m_dc = 0;
            else if (om != 2) m_dc = (m_dc + 1) % DIVN;
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", cur_req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            int e_osc, e_reg;
            e_osc = (m_mode != 2);
            e_reg = m_ia | (m_pa << 1) | (m_gp2 << 2) | (m_gp3 << 3) | (m_slow << 4)
                  | ((m_mode == 1) << 5) | ((m_mode >= 2) << 6) | (m_gp7 << 7);
            chk("cpu_clk_en", cpu_clk_en, m_mode == 0);
            chk("periph_clk_en", periph_clk_en, m_mode <= 1);
            chk("osc_run", osc_run, e_osc);
            chk("slow_tick", slow_tick, e_osc & ((m_slow == 0) | (m_dc == DIVN - 1)));
            chk("pwr_reg", pwr_reg, e_reg);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic pulse_irq(int n);
        @(negedge clk);
        wake_irq = 1'b1;
        idle_cyc(n);
        wake_irq = 1'b0;
    endtask

    task automatic pulse_pin(bit which_b);
        @(negedge clk);
        if (which_b) wake_b_n = 1'b0; else wake_a_n = 1'b0;
        @(negedge clk);
        wake_a_n = 1'b1;
        wake_b_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        idle_cyc(4);
        // R11: plain storage bits
        cur_req = "R11";
        wr(8'h8C);
        idle_cyc(2);
        wr(8'h00);
        // R2 then R5: idle entry and interrupt exit
        cur_req = "R2";
        wr(8'h01);
        wr(8'h21);
        idle_cyc(5);
        cur_req = "R5";
        pulse_irq(1);
        idle_cyc(3);
        // R8: write during idle ignored
        cur_req = "R8";
        wr(8'h01);
        wr(8'h21);
        wr(8'h9C);
        idle_cyc(2);
        pulse_irq(1);
        idle_cyc(2);
        // R4: broken and unarmed sequences
        cur_req = "R4";
        wr(8'h01);
        wr(8'h04);
        wr(8'h20);
        wr(8'h02);
        wr(8'h02);
        idle_cyc(1);
        wr(8'h01);
        wr(8'h41);
        idle_cyc(2);
        wr(8'h00);
        // R3 then R6: power-down, interrupt ignored, pin wake with warm-up
        cur_req = "R3";
        wr(8'h02);
        wr(8'h40);
        idle_cyc(3);
        cur_req = "R6";
        pulse_irq(3);
        wr(8'h00);
        pulse_pin(1'b1);
        idle_cyc(WARM + 4);
        wr(8'h02);
        wr(8'h42);
        idle_cyc(2);
        pulse_pin(1'b0);
        idle_cyc(WARM + 4);
        pulse_pin(1'b0);
        idle_cyc(2);
        // R7: slow-down divider
        cur_req = "R7";
        wr(8'h10);
        idle_cyc(3 * DIVN);
        // R9: slow with idle, then slow across power-down
        cur_req = "R9";
        wr(8'h11);
        wr(8'h31);
        idle_cyc(DIVN + 8);
        pulse_irq(1);
        wr(8'h12);
        wr(8'h52);
        idle_cyc(10);
        pulse_pin(1'b0);
        idle_cyc(WARM + DIVN);
        cur_req = "R7";
        wr(8'h00);
        idle_cyc(5);
        // R10: both armed, power-down wins
        cur_req = "R10";
        wr(8'h03);
        wr(8'h60);
        idle_cyc(3);
        pulse_pin(1'b1);
        idle_cyc(WARM + 4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule